// File: doc/BRIEF.md
# Memory Socket Bank Configuration and Address Decode

This block is the configuration front end of a memory controller that serves six memory-module sockets. Each socket is empty or carries a module of 8 MB or 32 MB. Static strap inputs describe which sockets are populated and which modules are large. Software reaches the block through a byte-wide I/O port interface, which offers four ports:

- a read-only module-size identification register;
- a read-only occupancy register;
- an indexed end-address programming register;
- a parity status register that always reports a clean state.

End addresses are counted in 8 MB units and chain from one socket to the next. Writing an end address into slot `s` moves socket `s-1` so that it starts where the previous slot ends.

From the per-socket base and enable state, the block decodes an incoming physical address. It produces a one-hot socket select and the offset inside the selected socket, or a no-hit flag. When the straps request auto-configuration, reset places every populated socket back to back from address zero.

Port reads are combinational. Their side effects, such as moving the read index, take place at the clock edge where `io_rd` is high.

Top module: `simm_cfg_decode`

## Requirements
- R1: A read of port 0x803 returns bit n = 1 exactly when socket n is populated with a 32 MB module. Bits 7:6 read 0.
- R2: A read of port 0x804 returns bits 7:6 = 1. Bit n (n < 6) reads 0 when socket n is populated and 1 when it is empty.
- R3: A read of port 0x804 sets the size-register read index to 0.
- R4: A write to port 0x820 takes a slot number from bits 7:5 and an end address from bits 4:0, in 8 MB units. It stores the end address into that slot.
- R5: A read of port 0x820 returns the stored end address of the slot at the read index in bits 4:0, with bits 7:5 = 0. The index then advances modulo 8.
- R6: A write of end address E to slot s, with 1 ≤ s ≤ 6, reconfigures socket s-1 when that socket is populated. The start S is the stored end of slot s-1, or 0 when s = 1. The socket is enabled exactly when E ≠ S, and its base becomes S × 8 MB. A write to slot 0 or slot 7 leaves every socket unchanged. An empty socket is never enabled.
- R7: A read of port 0x841 returns 0x01.
- R8: A read of any other port returns 0xFF. Writes to ports other than 0x820 change nothing.
- R9: Reset clears all end-address slots and the read index. With `auto_cfg` = 1, every populated socket is enabled, with bases assigned in ascending socket order from 0, each advancing by the module size. With `auto_cfg` = 0, all sockets are disabled.
- R10: Socket n matches an address A when it is enabled and base ≤ A < base + module size. The decode drives `sock_sel` one-hot for the match and `sock_off` = A − base. When nothing matches, `no_hit` = 1, `sock_sel` = 0 and `sock_off` = 0.
- R11: When several enabled sockets match, the highest-numbered one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_present | input | 6 | Static strap: socket populated |
| strap_big | input | 6 | Static strap: module is 32 MB (else 8 MB) |
| auto_cfg | input | 1 | Static strap: lay out sockets contiguously at reset |
| io_addr | input | 12 | I/O port address |
| io_rd | input | 1 | Read strobe; applies read side effects at the clock edge |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port (combinational) |
| phys_addr | input | 28 | Physical address to decode |
| sock_sel | output | 6 | One-hot winning socket |
| sock_off | output | 28 | Offset inside the winning socket |
| no_hit | output | 1 | No enabled socket contains the address |

## Verification
A wrong base or enable bit becomes visible on `sock_sel` and `sock_off` in the very cycle after the write that caused it, because decode is combinational on the registered map. A corrupted end-address slot shows up only when that slot is read back or used as the start of the next slot's write. The bench therefore walks the read index across all eight slots after each programming sequence. A read index that drifts or fails to clear shifts every later size-register read by one slot. For that reason the index is read back right after occupancy-register reads and across its wrap point.

// File: rtl/simm_pkg.sv
package simm_pkg;
  localparam int DATA_W = 8;

  typedef logic [DATA_W-1:0] io_byte_t;

  // Module size in 8 MB units: a large module spans four units.
  function automatic int unsigned units_of(input logic big);
    return big ? 4 : 1;
  endfunction

  // Chained start of a slot write: slot 1 always starts at zero.
  function automatic int unsigned chain_start(input int unsigned slot,
                                              input int unsigned prev_end);
    return (slot <= 1) ? 0 : prev_end;
  endfunction
endpackage

// File: rtl/simm_portregs.sv
module simm_portregs
  import simm_pkg::*;
#(
  parameter int NUM_SOCK  = 6,
  parameter int END_W     = 5,
  parameter int IO_AW     = 12,
  parameter logic [IO_AW-1:0] PORT_ID   = 12'h803,
  parameter logic [IO_AW-1:0] PORT_PRES = 12'h804,
  parameter logic [IO_AW-1:0] PORT_SIZE = 12'h820,
  parameter logic [IO_AW-1:0] PORT_PAR  = 12'h841
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SOCK-1:0] strap_present,
  input  logic [NUM_SOCK-1:0] strap_big,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic                io_rd,
  input  logic                io_wr,
  input  io_byte_t            io_wdata,
  output io_byte_t            io_rdata,
  output logic                slot_wr,
  output logic [DATA_W-END_W-1:0] slot_idx,
  output logic [END_W-1:0]    slot_end,
  output logic [END_W-1:0]    slot_start
);
  localparam int SLOT_W = DATA_W - END_W;
  localparam int NSLOT  = 1 << SLOT_W;

  logic [END_W-1:0]  end_q [NSLOT];
  logic [SLOT_W-1:0] rd_idx;

  // Named events for checks
  logic pres_rd, size_rd, par_rd, undef_rd;
  assign pres_rd  = io_rd && (io_addr == PORT_PRES);
  assign size_rd  = io_rd && (io_addr == PORT_SIZE);
  assign par_rd   = io_rd && (io_addr == PORT_PAR);
  assign undef_rd = io_rd && (io_addr != PORT_ID) && (io_addr != PORT_PRES)
                    && (io_addr != PORT_SIZE) && (io_addr != PORT_PAR);

  assign slot_wr  = io_wr && (io_addr == PORT_SIZE);
  assign slot_idx = io_wdata[DATA_W-1:END_W];
  assign slot_end = io_wdata[END_W-1:0];

  always_comb begin
    slot_start = '0;
    if (slot_idx != '0)
      slot_start = END_W'(chain_start(int'(slot_idx),
                                      int'(end_q[slot_idx - SLOT_W'(1)])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_idx <= '0;
    end else if (pres_rd) begin
      rd_idx <= '0;
    end else if (size_rd) begin
      rd_idx <= rd_idx + SLOT_W'(1);
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        end_q[g] <= '0;
      else if (slot_wr && (slot_idx == SLOT_W'(g)))
        end_q[g] <= slot_end;
    end
  end

  always_comb begin
    io_rdata = '1;
    unique case (io_addr)
      PORT_ID: begin
        io_rdata = '0;
        io_rdata[NUM_SOCK-1:0] = strap_present & strap_big;
      end
      PORT_PRES: begin
        io_rdata = '1;
        io_rdata[NUM_SOCK-1:0] = ~strap_present;
      end
      PORT_SIZE: begin
        io_rdata = '0;
        io_rdata[END_W-1:0] = end_q[rd_idx];
      end
      PORT_PAR: io_rdata = io_byte_t'(1);
      default:  io_rdata = '1;
    endcase
  end

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pres_rd |=> (rd_idx == '0)); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    size_rd |=> (rd_idx == $past(rd_idx) + SLOT_W'(1))); // R5
  AST_PARITY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    par_rd |-> (io_rdata == io_byte_t'(1))); // R7
  AST_PRES_TOP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    pres_rd |-> (io_rdata[DATA_W-1:NUM_SOCK] == '1)); // R2
  AST_UNDEF_READ: assert property (@(posedge clk) disable iff (!rst_n)
    undef_rd |-> (io_rdata == '1)); // R8
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd) |=> $stable(rd_idx)); // R5
endmodule

// File: rtl/simm_bankmap.sv
module simm_bankmap
  import simm_pkg::*;
#(
  parameter int NUM_SOCK = 6,
  parameter int END_W    = 5,
  parameter int SLOT_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SOCK-1:0] strap_present,
  input  logic [NUM_SOCK-1:0] strap_big,
  input  logic                auto_cfg,
  input  logic                slot_wr,
  input  logic [SLOT_W-1:0]   slot_idx,
  input  logic [END_W-1:0]    slot_end,
  input  logic [END_W-1:0]    slot_start,
  output logic [NUM_SOCK-1:0] sock_en,
  output logic [END_W-1:0]    sock_base [NUM_SOCK]
);
  // Contiguous reset layout: running sum of populated module sizes
  logic [END_W-1:0] auto_base [NUM_SOCK];
  always_comb begin
    logic [END_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SOCK; i++) begin
      auto_base[i] = acc;
      if (strap_present[i])
        acc = acc + END_W'(units_of(strap_big[i]));
    end
  end

  logic [NUM_SOCK-1:0] sock_hit_wr;
  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
    assign sock_hit_wr[g] = slot_wr && (slot_idx == SLOT_W'(g + 1))
                            && strap_present[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sock_en[g]   <= auto_cfg && strap_present[g];
        sock_base[g] <= auto_cfg ? auto_base[g] : '0;
      end else if (sock_hit_wr[g]) begin
        sock_en[g]   <= (slot_end != slot_start);
        sock_base[g] <= slot_start;
      end
    end

    AST_WR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      sock_hit_wr[g] |=> (sock_base[g] == $past(slot_start))); // R6
  end

  AST_EMPTY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sock_en & ~strap_present) == '0); // R6
  AST_EDGE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_wr && (slot_idx == '0 || slot_idx == SLOT_W'(NUM_SOCK + 1)))
    |=> $stable(sock_en)); // R6
endmodule

// File: rtl/simm_addrdec.sv
module simm_addrdec
  import simm_pkg::*;
#(
  parameter int NUM_SOCK  = 6,
  parameter int END_W     = 5,
  parameter int UNIT_LOG2 = 23,
  parameter int ADDR_W    = END_W + UNIT_LOG2
) (
  input  logic [ADDR_W-1:0]   phys_addr,
  input  logic [NUM_SOCK-1:0] sock_en,
  input  logic [END_W-1:0]    sock_base [NUM_SOCK],
  input  logic [NUM_SOCK-1:0] strap_big,
  output logic [NUM_SOCK-1:0] sock_sel,
  output logic [ADDR_W-1:0]   sock_off,
  output logic                no_hit
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0]    lo [NUM_SOCK];
  logic [EXT_W-1:0]    hi [NUM_SOCK];
  logic [NUM_SOCK-1:0] match;

  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_win
    assign lo[g] = EXT_W'(sock_base[g]) << UNIT_LOG2;
    assign hi[g] = lo[g] + (EXT_W'(units_of(strap_big[g])) << UNIT_LOG2);
    assign match[g] = sock_en[g] && (EXT_W'(phys_addr) >= lo[g])
                      && (EXT_W'(phys_addr) < hi[g]);
  end

  // Highest-numbered matching socket wins
  always_comb begin
    sock_sel = '0;
    sock_off = '0;
    for (int i = 0; i < NUM_SOCK; i++) begin
      if (match[i]) begin
        sock_sel = '0;
        sock_sel[i] = 1'b1;
        sock_off = ADDR_W'(EXT_W'(phys_addr) - lo[i]);
      end
    end
  end
  assign no_hit = (match == '0);

  always_comb begin
    AST_SEL_ENABLED: assert ((sock_sel & ~sock_en) == '0); // R10
    AST_SEL_ONEHOT: assert ($onehot0(sock_sel)); // R11
  end
endmodule

// File: rtl/simm_cfg_decode.sv
module simm_cfg_decode
  import simm_pkg::*;
#(
  parameter int NUM_SOCK  = 6,
  parameter int END_W     = 5,
  parameter int UNIT_LOG2 = 23,
  parameter int ADDR_W    = END_W + UNIT_LOG2,
  parameter int IO_AW     = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SOCK-1:0] strap_present,
  input  logic [NUM_SOCK-1:0] strap_big,
  input  logic                auto_cfg,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic                io_rd,
  input  logic                io_wr,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  input  logic [ADDR_W-1:0]   phys_addr,
  output logic [NUM_SOCK-1:0] sock_sel,
  output logic [ADDR_W-1:0]   sock_off,
  output logic                no_hit
);
  localparam int SLOT_W = DATA_W - END_W;

  logic                slot_wr;
  logic [SLOT_W-1:0]   slot_idx;
  logic [END_W-1:0]    slot_end;
  logic [END_W-1:0]    slot_start;
  logic [NUM_SOCK-1:0] sock_en;
  logic [END_W-1:0]    sock_base [NUM_SOCK];

  simm_portregs #(.NUM_SOCK(NUM_SOCK), .END_W(END_W), .IO_AW(IO_AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .strap_present(strap_present), .strap_big(strap_big),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .slot_wr(slot_wr), .slot_idx(slot_idx),
    .slot_end(slot_end), .slot_start(slot_start)
  );

  simm_bankmap #(.NUM_SOCK(NUM_SOCK), .END_W(END_W), .SLOT_W(SLOT_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .strap_present(strap_present), .strap_big(strap_big),
    .auto_cfg(auto_cfg),
    .slot_wr(slot_wr), .slot_idx(slot_idx),
    .slot_end(slot_end), .slot_start(slot_start),
    .sock_en(sock_en), .sock_base(sock_base)
  );

  simm_addrdec #(.NUM_SOCK(NUM_SOCK), .END_W(END_W), .UNIT_LOG2(UNIT_LOG2),
                 .ADDR_W(ADDR_W)) u_dec (
    .phys_addr(phys_addr), .sock_en(sock_en), .sock_base(sock_base),
    .strap_big(strap_big),
    .sock_sel(sock_sel), .sock_off(sock_off), .no_hit(no_hit)
  );

  AST_NOHIT_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
    no_hit |-> (sock_sel == '0 && sock_off == '0)); // R10
  AST_ID_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == IO_AW'(12'h803)) |-> (io_rdata[7:NUM_SOCK] == '0)); // R1
endmodule

// File: tb/tb_simm_cfg_decode.sv
module tb_simm_cfg_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  strap_present = '0;
  logic [5:0]  strap_big = '0;
  logic        auto_cfg = 1'b1;
  logic [11:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [27:0] phys_addr = '0;
  logic [5:0]  sock_sel;
  logic [27:0] sock_off;
  logic        no_hit;

  simm_cfg_decode dut (
    .clk(clk), .rst_n(rst_n), .strap_present(strap_present),
    .strap_big(strap_big), .auto_cfg(auto_cfg),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .phys_addr(phys_addr), .sock_sel(sock_sel),
    .sock_off(sock_off), .no_hit(no_hit)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string phase = "R9";

  // Behavioural reference state
  int m_end [8];
  int m_idx;
  int m_base [6];
  bit m_en [6];

  task automatic model_reset();
    int acc;
    acc = 0;
    for (int i = 0; i < 8; i++) m_end[i] = 0;
    m_idx = 0;
    for (int i = 0; i < 6; i++) begin
      m_en[i] = auto_cfg && strap_present[i];
      m_base[i] = auto_cfg ? acc : 0;
      if (strap_present[i]) acc += strap_big[i] ? 4 : 1;
    end
  endtask

  task automatic apply_reset(input logic [5:0] pres, input logic [5:0] big,
                             input logic ac);
    @(negedge clk);
    rst_n = 1'b0;
    strap_present = pres;
    strap_big = big;
    auto_cfg = ac;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check8(input string tag, input logic [7:0] act,
                        input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Read a port: expected value from the model, side effect after the edge
  task automatic io_read(input logic [11:0] a, input string tag);
    logic [7:0] exp;
    io_addr = a;
    io_rd = 1'b1;
    case (a)
      12'h803: exp = {2'b00, strap_present & strap_big};
      12'h804: exp = {2'b11, ~strap_present};
      12'h820: exp = 8'(m_end[m_idx] % 32);
      12'h841: exp = 8'h01;
      default: exp = 8'hFF;
    endcase
    #1;
    check8(tag, io_rdata, exp);
    @(posedge clk);
    if (a == 12'h804) m_idx = 0;
    else if (a == 12'h820) m_idx = (m_idx + 1) % 8;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic io_write(input logic [11:0] a, input logic [7:0] d);
    int s, e, st;
    io_addr = a;
    io_wdata = d;
    io_wr = 1'b1;
    @(posedge clk);
    if (a == 12'h820) begin
      s = d / 32;
      e = d % 32;
      st = (s <= 1) ? 0 : m_end[s - 1];
      m_end[s] = e;
      if (s >= 1 && s <= 6 && strap_present[s - 1]) begin
        m_en[s - 1] = (e != st);
        m_base[s - 1] = st;
      end
    end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // Address stimulus: unit boundaries, ends of units and interior points
  initial begin
    int k;
    longint u, sub;
    k = 0;
    forever begin
      @(negedge clk);
      u = (k * 7) % 32;
      case (k % 4)
        0: sub = 0;
        1: sub = 1;
        2: sub = (1 << 23) - 1;
        default: sub = 32'h0002345F + (k % 3) * (1 << 22);
      endcase
      phys_addr = 28'((u << 23) + sub);
      k++;
    end
  end

  // Decode compared against the model on every clock
  always @(negedge clk) begin
    longint a, lo, hi, eoff;
    logic [5:0] esel;
    bit ehit;
    #2;
    if (rst_n && !done) begin
      a = longint'(phys_addr);
      esel = '0; eoff = 0; ehit = 0;
      for (int i = 0; i < 6; i++) begin
        lo = longint'(m_base[i]) * (64'd1 << 23);
        hi = lo + (strap_big[i] ? 32 : 8) * (64'd1 << 20);
        if (m_en[i] && a >= lo && a < hi) begin
          esel = 6'(1 << i);
          eoff = a - lo;
          ehit = 1;
        end
      end
      n_chk++;
      if (sock_sel !== esel || sock_off !== 28'(eoff) || no_hit !== !ehit) begin
        n_bad++;
        $display("FAIL %s R10 decode addr=%07h: got sel=%b off=%07h nh=%b expected sel=%b off=%07h nh=%b",
                 phase, phys_addr, sock_sel, sock_off, no_hit, esel, 28'(eoff), !ehit);
      end
    end
  end

  initial begin
    // Mixed population, auto layout
    apply_reset(6'b111111, 6'b001100, 1'b1);
    phase = "R9";
    repeat (40) @(negedge clk);
    io_read(12'h803, "R1 id");
    io_read(12'h804, "R2 presence");
    io_read(12'h841, "R7 parity");
    io_read(12'h800, "R8 undefined port");
    io_read(12'h842, "R8 undefined port");
    for (int i = 0; i < 9; i++) io_read(12'h820, "R9 slots cleared");

    // Writes to other ports must change nothing
    phase = "R8";
    io_write(12'h804, 8'h25);
    io_write(12'h900, 8'h3F);
    io_write(12'h821, 8'h44);
    repeat (20) @(negedge clk);
    io_read(12'h804, "R3 presence clears index");
    for (int i = 0; i < 8; i++) io_read(12'h820, "R8 slots untouched");

    // Chained programming
    phase = "R6";
    io_write(12'h820, {3'd1, 5'd4});
    io_write(12'h820, {3'd2, 5'd4});   // zero size: socket 1 disabled
    io_write(12'h820, {3'd3, 5'd8});
    io_write(12'h820, {3'd4, 5'd12});
    io_write(12'h820, {3'd0, 5'd17});  // slot 0: no socket
    io_write(12'h820, {3'd7, 5'd30});  // slot 7: no socket
    repeat (40) @(negedge clk);

    // Overlap: socket 5 placed inside the 32 MB socket 2
    phase = "R11";
    io_write(12'h820, {3'd5, 5'd5});
    io_write(12'h820, {3'd6, 5'd9});
    repeat (60) @(negedge clk);

    phase = "R4";
    io_read(12'h804, "R3 presence clears index");
    for (int i = 0; i < 10; i++) io_read(12'h820, "R5 size readback");
    io_read(12'h820, "R5 index continues");
    io_read(12'h804, "R3 presence clears index");
    io_read(12'h820, "R5 restart at slot 0");
    io_read(12'h820, "R4 slot 1 value");

    // Sparse population, no auto layout
    apply_reset(6'b010110, 6'b000010, 1'b0);
    phase = "R9";
    repeat (40) @(negedge clk);
    io_read(12'h803, "R1 id sparse");
    io_read(12'h804, "R2 presence sparse");
    phase = "R6";
    io_write(12'h820, {3'd1, 5'd3});   // socket 0 empty
    io_write(12'h820, {3'd2, 5'd5});   // socket 1 at base 3
    io_write(12'h820, {3'd3, 5'd9});   // socket 2 at base 5
    io_write(12'h820, {3'd4, 5'd9});   // socket 3 empty
    io_write(12'h820, {3'd5, 5'd20});  // socket 4 at base 9
    repeat (60) @(negedge clk);
    io_read(12'h804, "R3 presence clears index");
    for (int i = 0; i < 8; i++) io_read(12'h820, "R5 size readback sparse");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule